// File: doc/BRIEF.md
# Test-Vector Bus Access Controller

This block is a bus master that runs only in test mode, clocked by the external test clock. A tester sends a two-bit request code on each cycle. The block turns each code into one transfer on the internal bus, so the tester can load an address, write a word or read a word at any on-chip location. A 32-bit test data channel carries the data. The channel is split here into input, output and output-enable; the pad that merges them sits outside the block.

Codes are pipelined. The block samples a code on a rising clock edge, and that code's transfer takes the following cycle. During that transfer the tester already presents the next code. An address transfer or a write transfer takes its data from the channel in the transfer cycle. A read transfer returns its data on the channel one cycle after it completes. Because of this, a read or a write must be followed by a code 11, which the block then uses as a turnaround. A slave that is not ready stalls the pipeline. The block shows the stall to the tester by dropping an acknowledge output on the falling clock edge.

Top module: `tvec_master`

## Requirements
- R1: A code is accepted on a rising edge when no transfer is in progress or the current transfer completes (`bus_ready` high). Its transfer occupies the next cycle with this encoding of `vec_code`:
  - 2'b11 gives an address-only transfer (`bus_seq`=0, `bus_wr`=0).
  - 2'b10 gives a sequential write (`bus_seq`=1, `bus_wr`=1).
  - 2'b01 gives a sequential read (`bus_seq`=1, `bus_wr`=0).
- R2: A code 11 whose predecessor was not a read or a write is an address load. The value on `tdat_i` when its transfer completes appears on `bus_addr` from the next cycle. It is held until the next address load.
- R3: During a write transfer, `bus_wdata` carries the channel value and the write goes to the held address.
- R4: The data of a completed read is driven on `tdat_o` with `tdat_oe` high in exactly the cycle after completion. `tdat_oe` is low in every other cycle.
- R5: A code 11 that directly follows a read or a write is a turnaround. Its transfer is address-only and leaves `bus_addr` unchanged whatever is on `tdat_i`.
- R6: `vec_ready` falls at the falling edge of any cycle whose transfer has `bus_ready` low. It rises again at the falling edge of the cycle in which the transfer completes. No code is accepted during the stall.
- R7: While a transfer is stalled, `bus_seq`, `bus_wr`, `bus_addr` and `bus_wdata` keep the values of the transfer's first cycle, even if `tdat_i` changes.
- R8: A code 00 that directly follows a code 11 ends the test. Its transfer is address-only. `test_done` goes high in the next cycle and stays high. Every later code is ignored, so the bus stays address-only at the same address.
- R9: A code 00 after a read, after a write, or as the first code after reset is ignored. It starts no transfer and `test_done` stays low.
- R10: Reset is asynchronous and active low. It clears `bus_addr`, `bus_seq`, `bus_wr`, `tdat_oe` and `test_done`, and sets `vec_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_code | input | 2 | Request code from the tester |
| vec_ready | output | 1 | Acknowledge; low while the pending transfer stalls |
| tdat_i | input | DW | Test channel, tester-driven value |
| tdat_o | output | DW | Test channel, read data from the block |
| tdat_oe | output | 1 | Test channel output enable |
| bus_addr | output | AW | Internal address bus |
| bus_seq | output | 1 | Transfer type: 1 sequential access, 0 address-only |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Internal write data |
| bus_rdata | input | DW | Internal read data |
| bus_ready | input | 1 | Slave ready; transfer completes when high |
| test_done | output | 1 | End-of-test reached |

## Verification
The assertions assume that `bus_ready` changes only shortly after a rising edge and then stays put until the next one. The acknowledge check needs this, because the falling-edge sample and the following rising-edge sample must see the same ready value. The bench meets the assumption by driving every input just after the rising edge, in the same place as the tester's codes. It holds the pending code steady across a stall, as a tester must. It also follows the protocol by placing a code 11 after every read and write. The one exception is a stray 00, which is sent on purpose to show that it is ignored.

// File: rtl/tvec_master.sv
module tvec_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    vec_code,
  output logic          vec_ready,
  input  logic [DW-1:0] tdat_i,
  output logic [DW-1:0] tdat_o,
  output logic          tdat_oe,
  output logic [AW-1:0] bus_addr,
  output logic          bus_seq,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          test_done
);

  typedef enum logic [2:0] {K_NONE, K_LOAD, K_TURN, K_WR, K_RD, K_END} kind_t;

  kind_t         cur_q;
  kind_t         nxt_kind;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] hold_q, rd_q;
  logic          wait_q, oe_q, done_q, stall_q;
  logic          xfer_on, advance, prev_rw, prev_11;

  assign xfer_on = (cur_q != K_NONE);
  assign advance = !xfer_on || bus_ready;
  assign prev_rw = (cur_q == K_WR) || (cur_q == K_RD);
  assign prev_11 = (cur_q == K_LOAD) || (cur_q == K_TURN);

  always_comb begin
    nxt_kind = K_NONE;
    if (!done_q) begin
      unique case (vec_code)
        2'b11:   nxt_kind = prev_rw ? K_TURN : K_LOAD;
        2'b10:   nxt_kind = K_WR;
        2'b01:   nxt_kind = K_RD;
        default: nxt_kind = prev_11 ? K_END : K_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= K_NONE;
      addr_q <= '0;
      hold_q <= '0;
      rd_q   <= '0;
      wait_q <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      wait_q <= xfer_on && !bus_ready;
      if (xfer_on && !bus_ready && !wait_q) hold_q <= tdat_i;
      if (cur_q == K_LOAD && bus_ready) addr_q <= bus_wdata[AW-1:0];
      if (cur_q == K_RD && bus_ready) rd_q <= bus_rdata;
      oe_q <= (cur_q == K_RD) && bus_ready;
      if (advance) begin
        cur_q <= nxt_kind;
        if (nxt_kind == K_END) done_q <= 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= xfer_on && !bus_ready;
  end

  assign vec_ready = !stall_q;
  assign bus_addr  = addr_q;
  assign bus_seq   = (cur_q == K_WR) || (cur_q == K_RD);
  assign bus_wr    = (cur_q == K_WR);
  assign bus_wdata = wait_q ? hold_q : tdat_i;
  assign tdat_o    = rd_q;
  assign tdat_oe   = oe_q;
  assign test_done = done_q;

endmodule

module tvec_master_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_on,
  input logic          bus_ready,
  input logic          bus_seq,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          tdat_oe,
  input logic          vec_ready,
  input logic          test_done
);

  a_r1_write_is_seq: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_seq);

  a_r2_addr_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_addr) |-> $past(xfer_on && !bus_seq && bus_ready));

  a_r4_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    tdat_oe |-> $past(xfer_on && bus_seq && !bus_wr && bus_ready));

  a_r6_ack_low_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_ready |-> (xfer_on && !bus_ready));

  a_r7_hold_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_on && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_seq) &&
                                 $stable(bus_wr) && $stable(bus_wdata)));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> test_done);

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done && $past(test_done)) |-> !bus_seq);

endmodule

bind tvec_master tvec_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_on   (xfer_on),
  .bus_ready (bus_ready),
  .bus_seq   (bus_seq),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tdat_oe   (tdat_oe),
  .vec_ready (vec_ready),
  .test_done (test_done)
);

// File: tb/tvec_master_bench.sv
`timescale 1ns/1ps
module tvec_master_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  vec_code = 2'b11;
  logic        vec_ready;
  logic [31:0] tdat_i = '0;
  logic [31:0] tdat_o;
  logic        tdat_oe;
  logic [31:0] bus_addr;
  logic        bus_seq, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;
  logic        test_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #4 clk = ~clk;

  tvec_master u_tvec_master (
    .clk(clk), .rst_n(rst_n), .vec_code(vec_code), .vec_ready(vec_ready),
    .tdat_i(tdat_i), .tdat_o(tdat_o), .tdat_oe(tdat_oe),
    .bus_addr(bus_addr), .bus_seq(bus_seq), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .test_done(test_done)
  );

  logic [31:0] mem [16];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h1000_0000 + i;
    end else if (bus_seq && bus_wr && bus_ready) begin
      mem[bus_addr[5:2]] <= bus_wdata;
    end
  end
  assign bus_rdata = mem[bus_addr[5:2]];

  typedef struct packed {
    logic [1:0]  code;
    logic [31:0] din;
    logic        seq, wr, oe, done;
    logic [31:0] addr;
    logic [31:0] tdo;
  } row_t;

  localparam row_t TBL [13] = '{
    '{2'b11, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0},
    '{2'b10, 32'h4,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0},
    '{2'b11, 32'hA5A5_1234, 1'b1, 1'b1, 1'b0, 1'b0, 32'h4, 32'h0},
    '{2'b01, 32'hDEAD_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4, 32'h0},
    '{2'b11, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 32'h4, 32'h0},
    '{2'b11, 32'h99,        1'b0, 1'b0, 1'b1, 1'b0, 32'h4, 32'hA5A5_1234},
    '{2'b01, 32'h8,         1'b0, 1'b0, 1'b0, 1'b0, 32'h4, 32'h0},
    '{2'b11, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 32'h8, 32'h0},
    '{2'b00, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 32'h8, 32'h1000_0002},
    '{2'b11, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h8, 32'h0},
    '{2'b10, 32'h44,        1'b0, 1'b0, 1'b0, 1'b1, 32'h8, 32'h0},
    '{2'b11, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h8, 32'h0},
    '{2'b01, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h8, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [1:0] code, input logic [31:0] din, input logic rdy);
    @(posedge clk);
    #1;
    vec_code  = code;
    tdat_i    = din;
    bus_ready = rdy;
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vec_code = 2'b11; tdat_i = '0; bus_ready = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 addr",  bus_addr, 32'h0);
    chk("R10 seq",   {31'b0, bus_seq}, 32'h0);
    chk("R10 wr",    {31'b0, bus_wr}, 32'h0);
    chk("R10 oe",    {31'b0, tdat_oe}, 32'h0);
    chk("R10 ready", {31'b0, vec_ready}, 32'h1);
    chk("R10 done",  {31'b0, test_done}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 5000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cyc_cnt);
      summary();
    end
  end

  initial begin
    do_reset();
    // R1 R2 R3 R4 R5 R8: pipelined table walk
    for (int k = 0; k < 13; k++) begin
      cyc(TBL[k].code, TBL[k].din, 1'b1);
      chk($sformatf("R1 seq row%0d", k),  {31'b0, bus_seq}, {31'b0, TBL[k].seq});
      chk($sformatf("R1 wr row%0d", k),   {31'b0, bus_wr},  {31'b0, TBL[k].wr});
      chk($sformatf("R2/R5 addr row%0d", k), bus_addr, TBL[k].addr);
      chk($sformatf("R4 oe row%0d", k),   {31'b0, tdat_oe}, {31'b0, TBL[k].oe});
      if (TBL[k].oe) chk($sformatf("R4 data row%0d", k), tdat_o, TBL[k].tdo);
      if (TBL[k].seq && TBL[k].wr) chk($sformatf("R3 wdata row%0d", k), bus_wdata, TBL[k].din);
      chk($sformatf("R8 done row%0d", k), {31'b0, test_done}, {31'b0, TBL[k].done});
    end

    // R6 R7: stalled write, then read-back
    do_reset();
    cyc(2'b11, 32'h0, 1'b1);
    cyc(2'b10, 32'h30, 1'b1);
    cyc(2'b11, 32'h5555_AAAA, 1'b0);
    chk("R6 ack low", {31'b0, vec_ready}, 32'h0);
    chk("R3 wdata", bus_wdata, 32'h5555_AAAA);
    cyc(2'b11, 32'h1111_1111, 1'b0);
    chk("R6 ack still low", {31'b0, vec_ready}, 32'h0);
    chk("R7 wdata held", bus_wdata, 32'h5555_AAAA);
    chk("R7 seq held", {30'b0, bus_seq, bus_wr}, 32'h3);
    chk("R7 addr held", bus_addr, 32'h30);
    cyc(2'b11, 32'h2222_2222, 1'b1);
    chk("R6 ack back", {31'b0, vec_ready}, 32'h1);
    chk("R7 wdata at completion", bus_wdata, 32'h5555_AAAA);
    cyc(2'b01, 32'h0, 1'b1);
    chk("R5 turn addr kept", bus_addr, 32'h30);
    chk("R5 turn address-only", {31'b0, bus_seq}, 32'h0);
    cyc(2'b11, 32'h0, 1'b1);
    chk("R1 read type", {30'b0, bus_seq, bus_wr}, 32'h2);
    cyc(2'b01, 32'h0, 1'b1);
    chk("R4 oe", {31'b0, tdat_oe}, 32'h1);
    chk("R7 stalled write landed", tdat_o, 32'h5555_AAAA);
    cyc(2'b00, 32'h0, 1'b1);
    chk("R4 second read type", {30'b0, bus_seq, bus_wr}, 32'h2);

    // R9: 00 after a read is ignored
    cyc(2'b11, 32'h0, 1'b1);
    chk("R4 second read data", tdat_o, 32'h5555_AAAA);
    chk("R9 no transfer", {31'b0, bus_seq}, 32'h0);
    chk("R9 done low", {31'b0, test_done}, 32'h0);
    cyc(2'b11, 32'h0, 1'b1);
    chk("R9 done still low", {31'b0, test_done}, 32'h0);
    chk("R4 oe single", {31'b0, tdat_oe}, 32'h0);

    summary();
  end

endmodule